// File: doc/BRIEF.md
# Walsh-Code Spreading Transmit Port

This block is the sending side of one port on a code-division on-chip switch. A processing element delivers whole packets to it over a valid/ready stream. The port buffers up to eight packets in a first-in first-out store. It spreads each packet onto a one-bit chip stream that a downstream summing stage combines with the streams of the other ports. Summation and despreading live elsewhere.

The packet at the head of the store raises a request toward the switch scheduler and shows its destination. The scheduler answers with a grant when that destination is free. The port then sends every packet bit, most significant first, as eight chips. A 0 bit is sent as the Walsh row picked by the destination address, and a 1 bit as the bitwise inverse of that row.

The input stream follows these back-pressure rules. A packet is taken on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is low exactly while the store is full, and it does not depend on `in_valid` or on a pop in the same cycle. A source seeing `in_ready` low must hold its packet and wait; nothing is ever discarded. The chip output has no ready signal, because the summing stage takes one chip per cycle without stalling. `chip_valid` marks the cycles that carry a chip.

Top module: `cdma_tx_port`

## Requirements
- R1: After reset the store is empty: `in_ready` is 1, and `buf_full`, `req` and `chip_valid` are 0.
- R2: A packet is stored on a rising edge where both `in_valid` and `in_ready` are 1. The store holds 8 packets.
- R3: With 8 packets stored, `buf_full` is 1 and `in_ready` is 0. Further offers are not taken. Stored packets leave in arrival order, and none is lost.
- R4: While the port is idle and holds a packet, `req` is 1 and `req_dst` equals that packet's destination field. No chip is sent until `grant` is seen high with `req` high.
- R5: In the cycle after an edge where `req` and `grant` are both 1, `chip_valid` goes to 1. It then stays 1 for exactly 16 × 8 = 128 consecutive cycles.
- R6: The 16-bit packet is `{group[1:0], source[2:0], destination[2:0], payload[7:0]}`. Its bits are sent from bit 15 down to bit 0.
- R7: For a packet bit b and a chip index c from 0 to 7 (sent in that order), the chip equals the parity of (destination AND c), XOR b. Destination 0 selects the all-zero row, which the switch reserves; sources use destinations 1 to 7.
- R8: When `chip_valid` is 0, `chip` is 0.
- R9: The head packet is removed only on the edge that ends its last chip. If the store was full, `buf_full` falls and `in_ready` rises in the first cycle after that last chip.
- R10: `grant` has no effect while a packet is being sent.
- R11: After each packet there is exactly one cycle in which `chip_valid` is 0. In that cycle `req` shows the next packet, if one is pending, and `req` is never 1 while chips are being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a packet |
| in_ready | output | 1 | Port can take a packet (store not full) |
| in_group | input | 2 | Group identifier of the offered packet |
| in_src | input | 3 | Source address of the offered packet |
| in_dst | input | 3 | Destination address; selects the Walsh row |
| in_payload | input | 8 | Payload of the offered packet |
| buf_full | output | 1 | Back-pressure flag to the source: store holds 8 packets |
| req | output | 1 | Head packet waits for scheduler access |
| req_dst | output | 3 | Destination of the waiting head packet |
| grant | input | 1 | Scheduler allows the waiting packet to start |
| chip_valid | output | 1 | A chip is present on `chip` this cycle |
| chip | output | 1 | Spread chip toward the summing stage |

## Verification
The hardest condition to reach from the ports is a full store that frees its first slot exactly on the last chip of a packet, while a source keeps offering a ninth packet against a low `in_ready`. The stimulus first loads eight packets with no grant, then holds a ninth offer for several cycles, and only after that grants the head. It then checks that `buf_full` falls in the first cycle after chip 128. The remaining seven packets are drained with the grant held high throughout. This shows the single idle cycle between packets, the arrival order, the absence of the refused ninth packet, and that a grant during a transfer changes nothing.

// File: rtl/cdma_tx_pkg.sv
package cdma_tx_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  // Entry (row, col) of a Sylvester Hadamard matrix in 0/1 form:
  // the parity of the bitwise AND of the two indices.
  function automatic logic walsh_bit(input int unsigned row, input int unsigned col);
    logic [31:0] m;
    m = 32'(row) & 32'(col);
    return ^m;
  endfunction

endpackage

// File: rtl/cdma_tx_walsh.sv
module cdma_tx_walsh #(
  parameter int unsigned CHIP_LEN = 8,
  parameter int unsigned IDX_W    = $clog2(CHIP_LEN)
) (
  input  logic [IDX_W-1:0] row,
  input  logic [IDX_W-1:0] col,
  output logic             code
);

  logic [CHIP_LEN-1:0] book [CHIP_LEN];

  for (genvar r = 0; r < CHIP_LEN; r++) begin : g_row
    for (genvar c = 0; c < CHIP_LEN; c++) begin : g_col
      assign book[r][c] = cdma_tx_pkg::walsh_bit(r, c);
    end
  end

  assign code = book[row][col];

endmodule

// File: rtl/cdma_tx_fifo.sv
module cdma_tx_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level;

  assign empty = (level == '0);
  assign full  = (level == CNT_W'(DEPTH));
  assign rdata = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/cdma_tx_serializer.sv
module cdma_tx_serializer #(
  parameter int unsigned PKT_W    = 16,
  parameter int unsigned CHIP_LEN = 8,
  parameter int unsigned DST_W    = 3,
  parameter int unsigned DST_LSB  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PKT_W-1:0] head,
  input  logic             head_valid,
  input  logic             grant,
  input  logic             code_bit,
  output logic             req,
  output logic [DST_W-1:0] req_dst,
  output logic             pop,
  output logic             chip_valid,
  output logic             chip,
  output logic [DST_W-1:0] row,
  output logic [DST_W-1:0] col
);

  import cdma_tx_pkg::*;

  localparam int unsigned BIT_W  = $clog2(PKT_W);
  localparam int unsigned CIDX_W = $clog2(CHIP_LEN);
  localparam logic [CIDX_W-1:0] LAST_CHIP = CIDX_W'(CHIP_LEN - 1);
  localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(PKT_W - 1);

  tx_state_e         state;
  logic [BIT_W-1:0]  bit_idx;
  logic [CIDX_W-1:0] chip_idx;
  logic [DST_W-1:0]  cur_dst;
  logic              sending;
  logic              end_of_bit;

  assign sending    = (state == TX_SEND);
  assign end_of_bit = (chip_idx == LAST_CHIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      bit_idx  <= '0;
      chip_idx <= '0;
      cur_dst  <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (head_valid && grant) begin
            state    <= TX_SEND;
            bit_idx  <= TOP_BIT;
            chip_idx <= '0;
            cur_dst  <= head[DST_LSB +: DST_W];
          end
        end
        TX_SEND: begin
          if (end_of_bit) begin
            chip_idx <= '0;
            if (bit_idx == '0) state   <= TX_IDLE;
            else               bit_idx <= bit_idx - 1'b1;
          end else begin
            chip_idx <= chip_idx + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    req        = !sending && head_valid;
    req_dst    = head[DST_LSB +: DST_W];
    pop        = sending && end_of_bit && (bit_idx == '0);
    chip_valid = sending;
    chip       = sending && (code_bit ^ head[bit_idx]);
    row        = cur_dst;
    col        = DST_W'(chip_idx);
  end

  // R5
  start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_valid) |-> $past(grant));

  // R9
  stop_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_valid) |-> $past(pop));

  // R10
  head_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |-> head_valid);

endmodule

// File: rtl/cdma_tx_port.sv
module cdma_tx_port #(
  parameter int unsigned CHIP_LEN = 8,
  parameter int unsigned GRP_W    = 2,
  parameter int unsigned PAY_W    = 8,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned ADDR_W   = $clog2(CHIP_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [GRP_W-1:0]  in_group,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic [PAY_W-1:0]  in_payload,
  output logic              buf_full,
  output logic              req,
  output logic [ADDR_W-1:0] req_dst,
  input  logic              grant,
  output logic              chip_valid,
  output logic              chip
);

  localparam int unsigned PKT_W = GRP_W + 2 * ADDR_W + PAY_W;

  logic [PKT_W-1:0]  wdata, head;
  logic              push, pop, empty, full, code_bit;
  logic [ADDR_W-1:0] row, col;

  assign wdata    = {in_group, in_src, in_dst, in_payload};
  assign in_ready = !full;
  assign buf_full = full;
  assign push     = in_valid && in_ready;

  cdma_tx_fifo #(
    .WIDTH(PKT_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (wdata),
    .pop   (pop),
    .rdata (head),
    .empty (empty),
    .full  (full)
  );

  cdma_tx_walsh #(
    .CHIP_LEN(CHIP_LEN),
    .IDX_W   (ADDR_W)
  ) u_walsh (
    .row  (row),
    .col  (col),
    .code (code_bit)
  );

  cdma_tx_serializer #(
    .PKT_W   (PKT_W),
    .CHIP_LEN(CHIP_LEN),
    .DST_W   (ADDR_W),
    .DST_LSB (PAY_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head),
    .head_valid (!empty),
    .grant      (grant),
    .code_bit   (code_bit),
    .req        (req),
    .req_dst    (req_dst),
    .pop        (pop),
    .chip_valid (chip_valid),
    .chip       (chip),
    .row        (row),
    .col        (col)
  );

  // R11
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !chip_valid);

  // R8
  idle_chip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> !chip);

endmodule

// File: tb/cdma_tx_port_tb.sv
`timescale 1ns/1ps
module cdma_tx_port_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, buf_full, req, grant, chip_valid, chip;
  logic [1:0] in_group;
  logic [2:0] in_src, in_dst, req_dst;
  logic [7:0] in_payload;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  logic [15:0] pkts [9];

  always #2.5 clk = ~clk;

  cdma_tx_port u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_group(in_group), .in_src(in_src), .in_dst(in_dst), .in_payload(in_payload),
    .buf_full(buf_full), .req(req), .req_dst(req_dst), .grant(grant),
    .chip_valid(chip_valid), .chip(chip)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] spread(input logic [15:0] p);
    logic [127:0] v;
    logic [2:0]   d;
    d = p[10:8];
    for (int b = 0; b < 16; b++) begin
      for (int c = 0; c < 8; c++) begin
        logic [2:0] ci;
        ci = 3'(c);
        v[127 - (b * 8 + c)] = (^(d & ci)) ^ p[15 - b];
      end
    end
    return v;
  endfunction

  task automatic push(input logic [15:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    {in_group, in_src, in_dst, in_payload} = p;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Called at a negedge with the packet at the head; returns at the negedge after the last chip.
  task automatic send(input logic [15:0] p, input bit keep_grant);
    logic [127:0] got, vals;
    check(req === 1'b1 && req_dst === p[10:8], "R4 req/req_dst", {req, req_dst}, {1'b1, p[10:8]});
    grant = 1'b1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      got[127 - i]  = chip;
      vals[127 - i] = chip_valid;
    end
    if (!keep_grant) grant = 1'b0;
    check(vals === '1, "R5 chip_valid run", vals, '1);
    check(got === spread(p), "R6 R7 chip stream", got, spread(p));
    @(negedge clk);
    check(chip_valid === 1'b0 && chip === 1'b0, "R8 R11 idle gap", {chip_valid, chip}, 2'b00);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; grant = 1'b0;
    {in_group, in_src, in_dst, in_payload} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(in_ready === 1'b1 && buf_full === 1'b0 && req === 1'b0 && chip_valid === 1'b0,
          "R1 reset state", {in_ready, buf_full, req, chip_valid}, 4'b1000);
  endtask

  task automatic t_wait_grant();
    logic [15:0] p;
    bit quiet;
    p = {2'd1, 3'd2, 3'd3, 8'hA5};
    push(p);
    check(req === 1'b1 && req_dst === 3'd3, "R4 request raised", {req, req_dst}, {1'b1, 3'd3});
    quiet = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (chip_valid !== 1'b0 || req !== 1'b1) quiet = 1'b0;
    end
    check(quiet, "R4 no chips without grant", quiet, 1'b1);
    send(p, 1'b0);
    check(req === 1'b0, "R9 store empty after send", req, 1'b0);
  endtask

  task automatic t_fill_drain();
    bit refused;
    for (int k = 0; k < 9; k++)
      pkts[k] = {2'(k), 3'(7 - (k % 8)), 3'((k % 7) + 1), 8'(8'h3C ^ (k * 8'h17))};
    for (int k = 0; k < 8; k++) push(pkts[k]);
    // R3
    check(buf_full === 1'b1 && in_ready === 1'b0, "R3 full flag", {buf_full, in_ready}, 2'b10);
    // R2: offer a ninth packet against a low ready
    in_valid = 1'b1;
    {in_group, in_src, in_dst, in_payload} = pkts[8];
    refused = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (in_ready !== 1'b0 || buf_full !== 1'b1) refused = 1'b0;
    end
    in_valid = 1'b0;
    check(refused, "R2 R3 ninth offer held off", refused, 1'b1);
    send(pkts[0], 1'b0);
    // R9
    check(buf_full === 1'b0 && in_ready === 1'b1, "R9 space freed after last chip",
          {buf_full, in_ready}, 2'b01);
    // R10 R11: grant held high through the rest
    for (int k = 1; k < 8; k++) send(pkts[k], 1'b1);
    grant = 1'b0;
    check(req === 1'b0 && chip_valid === 1'b0, "R3 no extra packet stored", {req, chip_valid}, 2'b00);
  endtask

  task automatic t_patterns();
    logic [15:0] a, b;
    a = {2'd3, 3'd7, 3'd6, 8'hFF};
    b = {2'd0, 3'd0, 3'd7, 8'h00};
    push(a);
    push(b);
    send(a, 1'b1);
    send(b, 1'b0);
    check(req === 1'b0, "R11 no request when empty", req, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wait_grant();
    t_fill_drain();
    t_patterns();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule